// File: doc/BRIEF.md
# Graded Demand Priority Vector Controller

This block turns twenty-four graded demand lines and two special interrupt lines into one interrupt request with a vector. The demand lines are served by three identical groups of eight. Each group holds a request register, a mask register, an in-service register and an eight-entry vector memory. Group 0 serves demands 1 to 8, group 1 serves demands 9 to 16 and group 2 serves demands 17 to 24. The two special lines, numbered 25 and 26, have fixed vectors. Each of them has its own mask bit.

Software sets up and steers the block through a one-cycle command port. A command names an opcode, a group, an entry index and a data byte. Each command either resets one group, clears all requests of a group, loads one vector entry, or changes a single in-service bit or mask bit. An interrupt handler pulses the acknowledge input while the request is high. One cycle later the block returns the winning vector with a valid strobe. At the same time it moves the winner from pending to in service.

Top module: `graded_vec_ctrl`

## Requirements
- R1: After reset, `intReq`, `ackValid` and `inService` are 0. All 24 demand masks and both special masks are set, and every vector entry is 0.
- R2: A request bit is set on the clock edge that first samples its input high after having sampled it low. A line held high sets it only once.
- R3: A line is pending when its request bit is set and its mask bit is clear. `intReq` is high exactly when any line is pending.
- R4: Among pending lines the lowest-numbered one wins. Demand 1 is the highest and demand 24 the lowest of the graded demands. Both special lines rank below all graded demands, and special 25 ranks above special 26.
- R5: When `intAck` is high while `intReq` is high, `ackValid` is 1 in the following cycle and carries the winner's vector. On that same edge the winner's request bit is cleared and, for a graded demand, its `inService` bit is set. When `intAck` is high while `intReq` is low, nothing changes and `ackValid` stays 0.
- R6: Opcode 3 writes `cmdData` into entry `cmdIdx` of group `cmdGroup`. Graded demand 8g+i+1 returns that entry as its vector. `inService` bit 8g+i belongs to the same demand.
- R7: Opcode 5 clears the mask bit and the request bit of one demand, selected by group and index. Opcode 6 sets that demand's mask bit. Opcode 4 clears that demand's in-service bit.
- R8: Opcode 1 clears all request and in-service bits of the named group and sets all eight of its mask bits. Rising edges on that group in the same cycle are lost. Other groups are unaffected.
- R9: Opcode 2 clears all eight request bits of the named group and leaves its masks unchanged.
- R10: Special line s (0 or 1) returns the fixed vector `SPEC_VEC0` or `SPEC_VEC1` and never sets an in-service bit. Opcode 8 clears its mask bit and opcode 7 sets it, with s taken from `cmdIdx[0]` and the group ignored. Its request bit latches while it is masked.
- R11: When a rising edge and a clear (from an acknowledge or a command) hit the same request bit in the same cycle, the edge wins. Group opcodes naming group 3 have no effect. Opcode 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| demandIn | input | 24 | Graded demand lines, bit k is demand k+1 |
| specialIn | input | 2 | Special interrupt lines 25 and 26 |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 4 | Command opcode |
| cmdGroup | input | 2 | Target group |
| cmdIdx | input | 3 | Entry or bit index within the group |
| cmdData | input | 8 | Vector data for opcode 3 |
| intAck | input | 1 | Interrupt acknowledge |
| intReq | output | 1 | Any line pending |
| ackValid | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| ackVector | output | 8 | Vector of the acknowledged line |
| inService | output | 24 | In-service bits of the graded demands |

## Verification
The bench uses the default build: three groups of eight, 8-bit vectors, and special vectors 0xF0 and 0xF1. With every demand's vector set to a distinct value, each acknowledge shows exactly which line won. A group index of 3 lies within the 2-bit group field but has no group behind it, so the out-of-range command path is reachable. Both special lines sit directly after demand 24, so their ranking against a pending graded demand is exercised in the same acknowledge sequence.

// File: rtl/gvc_pkg.sv
package gvc_pkg;
  localparam int GROUPS   = 3;
  localparam int GSIZE    = 8;
  localparam int VEC_W    = 8;
  localparam int NUM_SPEC = 2;
  localparam int IDX_W    = $clog2(GSIZE);
  localparam int GRP_W    = $clog2(GROUPS + 1);
  localparam int OP_W     = 4;
  localparam int NUM_GD   = GROUPS * GSIZE;
  localparam int NUM_ALL  = NUM_GD + NUM_SPEC;
  localparam int WIN_W    = $clog2(NUM_ALL);
  localparam int WG_W     = WIN_W - IDX_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP         = 4'd0,
    OP_GRP_RESET   = 4'd1,
    OP_CLR_ALL_REQ = 4'd2,
    OP_WR_VEC      = 4'd3,
    OP_CLR_ISR     = 4'd4,
    OP_ENABLE      = 4'd5,
    OP_SET_MASK    = 4'd6,
    OP_SPEC_MASK   = 4'd7,
    OP_SPEC_UNMASK = 4'd8
  } cmd_op_e;

  typedef struct packed {
    logic [GROUPS-1:0]   grpReset;
    logic [GROUPS-1:0]   clrAllReq;
    logic [GROUPS-1:0]   wrVec;
    logic [GROUPS-1:0]   clrIsr;
    logic [GROUPS-1:0]   enable;
    logic [GROUPS-1:0]   setMask;
    logic [NUM_SPEC-1:0] specMaskSet;
    logic [NUM_SPEC-1:0] specMaskClr;
    logic [IDX_W-1:0]    idx;
    logic [VEC_W-1:0]    data;
    logic                ack;
    logic [WIN_W-1:0]    winner;
  } strobe_t;
endpackage

// File: rtl/gvc_control.sv
module gvc_control
  import gvc_pkg::*;
(
  input  logic                cmdValid,
  input  logic [OP_W-1:0]     cmdOp,
  input  logic [GRP_W-1:0]    cmdGroup,
  input  logic [IDX_W-1:0]    cmdIdx,
  input  logic [VEC_W-1:0]    cmdData,
  input  logic                intAck,
  input  logic [NUM_ALL-1:0]  pending,
  output logic                intReq,
  output strobe_t             strb
);
  logic [WIN_W-1:0]  winIdx;
  logic [GROUPS-1:0] grpSel;
  cmd_op_e           op;

  assign op     = cmd_op_e'(cmdOp);
  assign intReq = |pending;

  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    winIdx = '0;
    for (int i = NUM_ALL - 1; i >= 0; i--) begin
      if (pending[i]) winIdx = WIN_W'(i);
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gSel
    assign grpSel[g] = cmdValid && (cmdGroup == GRP_W'(g));
  end

  always_comb begin
    strb           = '0;
    strb.idx       = cmdIdx;
    strb.data      = cmdData;
    strb.ack       = intAck && intReq;
    strb.winner    = winIdx;
    strb.grpReset  = (op == OP_GRP_RESET)   ? grpSel : '0;
    strb.clrAllReq = (op == OP_CLR_ALL_REQ) ? grpSel : '0;
    strb.wrVec     = (op == OP_WR_VEC)      ? grpSel : '0;
    strb.clrIsr    = (op == OP_CLR_ISR)     ? grpSel : '0;
    strb.enable    = (op == OP_ENABLE)      ? grpSel : '0;
    strb.setMask   = (op == OP_SET_MASK)    ? grpSel : '0;
    if (cmdValid && op == OP_SPEC_MASK)   strb.specMaskSet[cmdIdx[0]] = 1'b1;
    if (cmdValid && op == OP_SPEC_UNMASK) strb.specMaskClr[cmdIdx[0]] = 1'b1;
  end
endmodule

// File: rtl/gvc_datapath.sv
module gvc_datapath
  import gvc_pkg::*;
#(
  parameter logic [VEC_W-1:0] SPEC_VEC0 = 8'hF0,
  parameter logic [VEC_W-1:0] SPEC_VEC1 = 8'hF1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_GD-1:0]   demandIn,
  input  logic [NUM_SPEC-1:0] specialIn,
  input  strobe_t             strb,
  output logic [NUM_ALL-1:0]  pending,
  output logic [NUM_GD-1:0]   inService,
  output logic                ackValid,
  output logic [VEC_W-1:0]    ackVector
);
  localparam logic [VEC_W-1:0] SPEC_TAB [NUM_SPEC] = '{SPEC_VEC0, SPEC_VEC1};

  logic [NUM_ALL-1:0] allIn, demPrev, rise, ackHit;
  logic [GSIZE-1:0]   idxBit;
  logic [VEC_W-1:0]   grpVecSel [GROUPS];
  logic [VEC_W-1:0]   selVec;
  logic [WG_W-1:0]    winGrp;

  assign allIn  = {specialIn, demandIn};
  assign rise   = allIn & ~demPrev;
  assign ackHit = strb.ack ? (NUM_ALL'(1) << strb.winner) : '0;
  assign idxBit = GSIZE'(1) << strb.idx;
  assign winGrp = strb.winner[WIN_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) demPrev <= '0;
    else       demPrev <= allIn;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gGrp
    logic [GSIZE-1:0] reqR, maskR, isrR;
    logic [GSIZE-1:0] gRise, gAck, clrReq, clrMask, setMaskB, clrIsrB;
    logic [VEC_W-1:0] vecMem [GSIZE];

    assign gRise    = rise[g*GSIZE +: GSIZE];
    assign gAck     = ackHit[g*GSIZE +: GSIZE];
    assign clrMask  = strb.enable[g]  ? idxBit : '0;
    assign clrReq   = (strb.clrAllReq[g] ? '1 : '0) | clrMask | gAck;
    assign setMaskB = strb.setMask[g] ? idxBit : '0;
    assign clrIsrB  = strb.clrIsr[g]  ? idxBit : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqR  <= '0;
        maskR <= '1;
        isrR  <= '0;
      end else if (strb.grpReset[g]) begin
        reqR  <= '0;
        maskR <= '1;
        isrR  <= '0;
      end else begin
        reqR  <= (reqR & ~clrReq) | gRise;
        maskR <= (maskR & ~clrMask) | setMaskB;
        isrR  <= (isrR & ~clrIsrB) | gAck;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < GSIZE; e++) vecMem[e] <= '0;
      end else if (strb.wrVec[g]) begin
        vecMem[strb.idx] <= strb.data;
      end
    end

    assign pending[g*GSIZE +: GSIZE]   = reqR & ~maskR;
    assign inService[g*GSIZE +: GSIZE] = isrR;
    assign grpVecSel[g]                = vecMem[strb.winner[IDX_W-1:0]];
  end

  // special lines: fixed vectors, own mask, no in-service tracking
  logic [NUM_SPEC-1:0] specReq, specMask;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      specReq  <= '0;
      specMask <= '1;
    end else begin
      specReq  <= (specReq & ~ackHit[NUM_ALL-1:NUM_GD]) | rise[NUM_ALL-1:NUM_GD];
      specMask <= (specMask & ~strb.specMaskClr) | strb.specMaskSet;
    end
  end
  assign pending[NUM_ALL-1:NUM_GD] = specReq & ~specMask;

  always_comb begin
    selVec = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (winGrp == WG_W'(g)) selVec = grpVecSel[g];
    end
    for (int s = 0; s < NUM_SPEC; s++) begin
      if (strb.winner == WIN_W'(NUM_GD + s)) selVec = SPEC_TAB[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackVector <= '0;
    end else begin
      ackValid <= strb.ack;
      if (strb.ack) ackVector <= selVec;
    end
  end
endmodule

// File: rtl/graded_vec_ctrl.sv
module graded_vec_ctrl
  import gvc_pkg::*;
#(
  parameter logic [VEC_W-1:0] SPEC_VEC0 = 8'hF0,
  parameter logic [VEC_W-1:0] SPEC_VEC1 = 8'hF1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_GD-1:0]   demandIn,
  input  logic [NUM_SPEC-1:0] specialIn,
  input  logic                cmdValid,
  input  logic [OP_W-1:0]     cmdOp,
  input  logic [GRP_W-1:0]    cmdGroup,
  input  logic [IDX_W-1:0]    cmdIdx,
  input  logic [VEC_W-1:0]    cmdData,
  input  logic                intAck,
  output logic                intReq,
  output logic                ackValid,
  output logic [VEC_W-1:0]    ackVector,
  output logic [NUM_GD-1:0]   inService
);
  strobe_t            strb;
  logic [NUM_ALL-1:0] pending;

  gvc_control uCtrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdGroup (cmdGroup),
    .cmdIdx   (cmdIdx),
    .cmdData  (cmdData),
    .intAck   (intAck),
    .pending  (pending),
    .intReq   (intReq),
    .strb     (strb)
  );

  gvc_datapath #(.SPEC_VEC0(SPEC_VEC0), .SPEC_VEC1(SPEC_VEC1)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .demandIn  (demandIn),
    .specialIn (specialIn),
    .strb      (strb),
    .pending   (pending),
    .inService (inService),
    .ackValid  (ackValid),
    .ackVector (ackVector)
  );
endmodule

// File: rtl/gvc_checker.sv
module gvc_checker
  import gvc_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [NUM_GD-1:0]   demandIn,
  input logic [NUM_SPEC-1:0] specialIn,
  input logic                cmdValid,
  input logic [OP_W-1:0]     cmdOp,
  input logic [GRP_W-1:0]    cmdGroup,
  input logic                intAck,
  input logic                intReq,
  input logic                ackValid,
  input logic [NUM_GD-1:0]   inService
);
  assert_ack_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq) |=> ackValid);

  assert_no_spurious_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(intAck && intReq) |=> !ackValid);

  assert_isr_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !(intAck && intReq)) |=> $stable(inService));

  assert_group0_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 4'd1 && cmdGroup == '0) |=> (inService[GSIZE-1:0] == '0));

  assert_no_edge_no_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (demandIn == '0 && specialIn == '0 && !intReq && !cmdValid) |=> !intReq);
endmodule

bind graded_vec_ctrl gvc_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .demandIn  (demandIn),
  .specialIn (specialIn),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .cmdGroup  (cmdGroup),
  .intAck    (intAck),
  .intReq    (intReq),
  .ackValid  (ackValid),
  .inService (inService)
);

// File: tb/sim_graded_vec_ctrl.sv
module sim_graded_vec_ctrl;
  import gvc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [VEC_W-1:0] SV0 = 8'hF0, SV1 = 8'hF1;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NUM_GD-1:0] demandIn = '0;
  logic [NUM_SPEC-1:0] specialIn = '0;
  logic cmdValid = 1'b0, intAck = 1'b0;
  logic [OP_W-1:0] cmdOp = '0;
  logic [GRP_W-1:0] cmdGroup = '0;
  logic [IDX_W-1:0] cmdIdx = '0;
  logic [VEC_W-1:0] cmdData = '0;
  logic intReq, ackValid;
  logic [VEC_W-1:0] ackVector;
  logic [NUM_GD-1:0] inService;

  graded_vec_ctrl #(.SPEC_VEC0(SV0), .SPEC_VEC1(SV1)) u0 (
    .clk(clk), .rstN(rstN), .demandIn(demandIn), .specialIn(specialIn),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdGroup(cmdGroup), .cmdIdx(cmdIdx),
    .cmdData(cmdData), .intAck(intAck), .intReq(intReq), .ackValid(ackValid),
    .ackVector(ackVector), .inService(inService));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0, nBad = 0;
  bit mReq [NUM_ALL];
  bit mMask [NUM_ALL];
  bit mPrev [NUM_ALL];
  bit mIsr [NUM_GD];
  int mVec [NUM_GD];
  bit mAckValid;
  int mAckVec;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nCmp++; nBad++;
    $display("FAIL R5 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic check(input int act, input int exp, input string tag);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic mReset();
    for (int i = 0; i < NUM_ALL; i++) begin mReq[i] = 0; mMask[i] = 1; mPrev[i] = 0; end
    for (int i = 0; i < NUM_GD; i++) begin mIsr[i] = 0; mVec[i] = 0; end
    mAckValid = 0; mAckVec = 0;
  endtask

  function automatic int mWinner();
    for (int i = 0; i < NUM_ALL; i++) if (mReq[i] && !mMask[i]) return i;
    return -1;
  endfunction

  task automatic mStep();
    int w = mWinner();
    bit ack = intAck && (w >= 0);
    int g = int'(cmdGroup);
    int op = int'(cmdOp);
    int ix = int'(cmdIdx);
    bit gv = cmdValid && (g < GROUPS);
    bit [NUM_ALL-1:0] inAll = {specialIn, demandIn};
    mAckValid = ack;
    if (ack) mAckVec = (w < NUM_GD) ? mVec[w] : ((w == NUM_GD) ? int'(SV0) : int'(SV1));
    for (int i = 0; i < NUM_ALL; i++) begin
      bit r = inAll[i] && !mPrev[i];
      if (i < NUM_GD) begin
        bit mine = gv && (i / GSIZE == g);
        bit hit = mine && (i % GSIZE == ix);
        if (mine && op == 1) begin
          mReq[i] = 0; mIsr[i] = 0; mMask[i] = 1;
        end else begin
          if (mine && op == 2) mReq[i] = 0;
          if (hit && op == 5) begin mReq[i] = 0; mMask[i] = 0; end
          if (hit && op == 6) mMask[i] = 1;
          if (hit && op == 4) mIsr[i] = 0;
          if (ack && w == i) begin mReq[i] = 0; mIsr[i] = 1; end
          if (r) mReq[i] = 1;
        end
      end else begin
        if (cmdValid && op == 7 && (ix % 2) == i - NUM_GD) mMask[i] = 1;
        if (cmdValid && op == 8 && (ix % 2) == i - NUM_GD) mMask[i] = 0;
        if (ack && w == i) mReq[i] = 0;
        if (r) mReq[i] = 1;
      end
    end
    for (int i = 0; i < NUM_ALL; i++) mPrev[i] = inAll[i];
    if (gv && op == 3) mVec[g * GSIZE + ix] = int'(cmdData);
  endtask

  task automatic compareAll();
    logic [NUM_GD-1:0] isrExp;
    for (int i = 0; i < NUM_GD; i++) isrExp[i] = mIsr[i];
    check(int'(intReq), int'(mWinner() >= 0), "R3 model intReq");
    check(int'(ackValid), int'(mAckValid), "R5 model ackValid");
    if (mAckValid) check(int'(ackVector), mAckVec, "R6 model ackVector");
    check(int'(inService), int'(isrExp), "R7 model inService");
  endtask

  task automatic tick();
    @(posedge clk);
    mStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic cmd(input int op, input int g, input int ix, input int d);
    cmdValid = 1; cmdOp = OP_W'(op); cmdGroup = GRP_W'(g);
    cmdIdx = IDX_W'(ix); cmdData = VEC_W'(d);
    tick();
    cmdValid = 0; cmdOp = '0;
  endtask

  task automatic ack();
    intAck = 1; tick(); intAck = 0;
  endtask

  initial begin
    mReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check(int'(intReq), 0, "R1 intReq");
    check(int'(ackValid), 0, "R1 ackValid");
    check(int'(inService), 0, "R1 inService");
    demandIn[0] = 1; tick();
    check(int'(intReq), 0, "R1 masked after reset");
    demandIn[0] = 0; tick();
    // R6 load distinct vectors
    for (int g = 0; g < GROUPS; g++)
      for (int i = 0; i < GSIZE; i++) cmd(3, g, i, 8'h40 + g * GSIZE + i);
    // R3 masked demand latches but does not request
    demandIn[2] = 1; tick();
    check(int'(intReq), 0, "R3 masked demand");
    cmd(5, 0, 2, 0);
    check(int'(intReq), 0, "R7 enable clears request");
    demandIn[2] = 0; tick();
    demandIn[2] = 1; tick();
    check(int'(intReq), 1, "R2 rising edge");
    ack();
    check(int'(ackVector), 8'h42, "R5 vector demand 3");
    check(int'(inService), 24'h000004, "R5 in-service set");
    check(int'(intReq), 0, "R5 request cleared");
    repeat (3) tick();
    check(int'(intReq), 0, "R2 held level no relatch");
    demandIn[2] = 0; tick();
    // R4 priority across groups
    cmd(5, 1, 2, 0); cmd(5, 2, 4, 0);
    demandIn[20] = 1; demandIn[10] = 1; tick();
    ack();
    check(int'(ackVector), 8'h4A, "R4 group 1 over group 2");
    ack();
    check(int'(ackVector), 8'h54, "R4 then group 2");
    check(int'(inService), 24'h100404, "R5 in-service three bits");
    // R7 clear in-service, set mask
    cmd(4, 1, 2, 0);
    check(int'(inService), 24'h100004, "R7 clear in-service");
    cmd(6, 2, 4, 0);
    demandIn[20] = 0; tick();
    demandIn[20] = 1; tick();
    check(int'(intReq), 0, "R7 set mask blocks");
    // R9 clear all requests keeps masks
    cmd(5, 1, 3, 0);
    demandIn[11] = 1; tick();
    check(int'(intReq), 1, "R9 pending before clear");
    cmd(2, 1, 0, 0);
    check(int'(intReq), 0, "R9 requests cleared");
    demandIn[11] = 0; tick();
    demandIn[11] = 1; tick();
    check(int'(intReq), 1, "R9 mask kept");
    ack();
    check(int'(inService), 24'h100804, "R5 demand 12 in service");
    // R8 group reset
    cmd(1, 1, 0, 0);
    check(int'(inService), 24'h100004, "R8 group 1 cleared only");
    demandIn[11] = 0; tick();
    demandIn[11] = 1; tick();
    check(int'(intReq), 0, "R8 masks set");
    // R11 group 3 ignored
    cmd(1, 3, 0, 0);
    check(int'(inService), 24'h100004, "R11 group 3 ignored");
    // R10 specials
    specialIn[0] = 1; tick();
    check(int'(intReq), 0, "R10 special masked at reset");
    cmd(8, 0, 0, 0);
    check(int'(intReq), 1, "R10 latched while masked");
    ack();
    check(int'(ackVector), 8'hF0, "R10 special 25 vector");
    check(int'(inService), 24'h100004, "R10 no in-service");
    cmd(8, 2, 1, 0);
    specialIn[1] = 1; demandIn[2] = 1; tick();
    ack();
    check(int'(ackVector), 8'h42, "R4 graded over special");
    ack();
    check(int'(ackVector), 8'hF1, "R10 special 26 vector");
    // R11 edge beats acknowledge clear
    cmd(4, 0, 2, 0);
    demandIn[2] = 0; tick();
    demandIn[2] = 1; tick();
    demandIn[2] = 0; tick();
    demandIn[2] = 1; intAck = 1; tick(); intAck = 0;
    check(int'(ackVector), 8'h42, "R11 ack vector");
    check(int'(intReq), 1, "R11 edge wins over ack clear");
    ack();
    check(int'(intReq), 0, "R11 then cleared");
    // R5 ack without pending ignored
    ack();
    check(int'(ackValid), 0, "R5 ack ignored when idle");
    check(int'(inService), 24'h100004, "R5 idle ack no change");
    repeat (2) tick();
    summary();
    $finish;
  end
endmodule